// File: doc/BRIEF.md
# Two-Tone Spectral Band Classifier

This block takes the magnitude half of a 2048-point spectrum, taken at 1 MHz from a signal made of two summed tones, and works out what each tone is. Magnitudes arrive one per accepted beat, in rising bin order. The block merges neighbouring bins into 5 kHz bands and keeps the summed squared magnitude of each band. When a band ends, an iterative integer square root turns that energy into a band amplitude, and a two-place ranking keeps the two strongest bands.

A tone whose band amplitude is above a fixed-point threshold is labelled a sine. Otherwise it is labelled a triangle, because a triangle's third harmonic draws energy away from its fundamental. Once the last bin has been folded in, the block sends a six-byte command frame over a valid/ready byte port. The frame gives the type and frequency code of each tone, with the lower-frequency tone first.

A start strobe opens each spectrum. It discards any partial work and clears the ranking.

Top module: `spectral_peak_classifier`

## Requirements
- R1: After reset `out_valid` and `bin_ready` are 0. `bin_ready` stays 0 until `start` is pulsed, and it is 1 on the cycle after the pulse.
- R2: After `start`, accepted magnitudes are taken as bins 35 to 999 in order. Bin i belongs to band round(i·1 000 000 / (2048·5000)), so bin 999 forms band 98 by itself.
- R3: A band's amplitude is floor(sqrt(sum of squared magnitudes of its bins)). Magnitudes are unsigned Q8.8, so the amplitude is also Q8.8.
- R4: A band amplitude above the first-place value moves first place down to second place. An amplitude strictly between the two replaces second place only. An amplitude equal to first place is ignored.
- R5: The type byte is 0 (sine) when the amplitude is greater than `THRESH_Q`, which defaults to 1459, about 5.7 in Q8.8. Otherwise the type byte is 1 (triangle), and an amplitude of exactly 1459 gives 1.
- R6: The frequency byte of a band with index b is floor(5·b/2). For example, bin 82 (band 8) gives 20, bin 143 (band 14) gives 35 and bin 999 gives 245.
- R7: The frame is 0xFF, the type byte of the lower-band tone, its frequency byte, the type byte of the higher-band tone, its frequency byte, 0xFE. The order follows band index, not strength.
- R8: A byte is held stable while `out_valid` is high and `out_ready` is low. Exactly six bytes are sent, and then `out_valid` falls.
- R9: If fewer than two bands reach the ranking, the empty place is reported with frequency byte 0 and type byte 1, and it comes first in the frame.
- R10: `bin_ready` drops while a band amplitude is being computed. The final band, including a single-bin band at bin 999, is still ranked.
- R11: A `start` pulse in the middle of a spectrum throws away all earlier bins. The next frame reflects only the bins sent after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start-of-spectrum strobe, one cycle |
| bin_valid | input | 1 | Magnitude on `bin_mag` is offered |
| bin_mag | input | 16 | Bin magnitude, unsigned Q8.8 |
| bin_ready | output | 1 | Block takes the offered magnitude this cycle |
| out_valid | output | 1 | Frame byte on `out_byte` is offered |
| out_ready | input | 1 | Consumer takes the frame byte this cycle |
| out_byte | output | 8 | Frame byte |

## Verification
The spectra used are:
- a strong low tone with a weak high tone;
- the same pair with the strengths swapped, which shows that frame order follows frequency rather than rank;
- a pair in which each bin alone is below the threshold but the two bins together in one band are above it, which shows that energy is summed per band;
- a pair of amplitudes exactly at the threshold and one step above it;
- a single tone, and two equal tones, which leave second place empty by different routes;
- a lone strong bin at index 999, which shows the closing band is flushed.

One run stalls the byte consumer to show that bytes are held. Another restarts in the middle of a spectrum to show that stale energy is dropped.

// File: rtl/spk_pkg.sv
package spk_pkg;
    localparam int MAG_W      = 16;
    localparam int BIN_W      = 11;
    localparam int BAND_W     = 7;
    localparam int CODE_W     = 8;
    localparam int SAMPLE_HZ  = 1_000_000;
    localparam int FFT_N      = 2048;
    localparam int BAND_HZ    = 5000;
    localparam int FIRST_BIN  = 35;
    localparam int LAST_BIN   = 999;
    localparam int ACC_GUARD  = 5;
    localparam int ACC_W      = 2 * MAG_W + ACC_GUARD;
    localparam int RAD_W      = ACC_W + (ACC_W % 2);
    localparam int AMP_W      = RAD_W / 2;
    localparam int FRAME_LEN  = 6;
    localparam logic [7:0] FRAME_HEAD = 8'hFF;
    localparam logic [7:0] FRAME_TAIL = 8'hFE;

    typedef struct packed {
        logic [AMP_W-1:0]  amp;
        logic [BAND_W-1:0] band;
    } band_peak_t;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_RUN,
        ACC_FLUSH,
        ACC_WAIT
    } acc_state_e;

    // Rounded band index of a bin: round(bin * Fs / (N * band width)).
    function automatic logic [BAND_W-1:0] band_of(input logic [BIN_W-1:0] bin);
        logic [63:0] num;
        logic [63:0] den;
        num = 64'(bin) * 64'(2 * SAMPLE_HZ) + 64'(FFT_N) * 64'(BAND_HZ);
        den = 64'(2 * FFT_N) * 64'(BAND_HZ);
        band_of = BAND_W'(num / den);
    endfunction

    // Frequency byte of a band: floor(2.5 * band).
    function automatic logic [CODE_W-1:0] freq_code(input logic [BAND_W-1:0] band);
        logic [CODE_W+1:0] t;
        t = (CODE_W + 2)'(band) * (CODE_W + 2)'(5);
        freq_code = CODE_W'(t >> 1);
    endfunction
endpackage

// File: rtl/spk_band_accum.sv
module spk_band_accum
    import spk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              bin_valid,
    input  logic [MAG_W-1:0]  bin_mag,
    output logic              bin_ready,
    input  logic              sqrt_busy,
    input  logic              res_valid,
    output logic              job_valid,
    output logic [ACC_W-1:0]  job_energy,
    output logic [BAND_W-1:0] job_band,
    output logic              spec_done
);
    acc_state_e        state;
    logic [BIN_W-1:0]  bin_idx;
    logic [BAND_W-1:0] cur_band;
    logic [BAND_W-1:0] bin_band;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  bin_sq;
    logic              have;
    logic              accept;
    logic              band_change;

    always_comb begin
        bin_band    = band_of(bin_idx);
        bin_sq      = ACC_W'(bin_mag) * ACC_W'(bin_mag);
        bin_ready   = (state == ACC_RUN) && !sqrt_busy;
        accept      = bin_ready && bin_valid;
        band_change = have && (bin_band != cur_band);
        job_valid   = (accept && band_change) || ((state == ACC_FLUSH) && !sqrt_busy);
        job_energy  = acc;
        job_band    = cur_band;
        spec_done   = (state == ACC_WAIT) && !sqrt_busy && !res_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ACC_IDLE;
            bin_idx  <= '0;
            cur_band <= '0;
            acc      <= '0;
            have     <= 1'b0;
        end else if (start) begin
            state    <= ACC_RUN;
            bin_idx  <= BIN_W'(FIRST_BIN);
            cur_band <= '0;
            acc      <= '0;
            have     <= 1'b0;
        end else begin
            case (state)
                ACC_RUN: begin
                    if (accept) begin
                        acc      <= band_change ? bin_sq : acc + bin_sq;
                        cur_band <= bin_band;
                        have     <= 1'b1;
                        bin_idx  <= bin_idx + 1'b1;
                        if (bin_idx == BIN_W'(LAST_BIN))
                            state <= ACC_FLUSH;
                    end
                end
                ACC_FLUSH: if (!sqrt_busy) state <= ACC_WAIT;
                ACC_WAIT:  if (!sqrt_busy && !res_valid) state <= ACC_IDLE;
                default:   state <= ACC_IDLE;
            endcase
        end
    end

    AST_BAND_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        (accept && have && !start) |-> (bin_band >= cur_band)) else $error("band order"); // R2
endmodule

// File: rtl/spk_isqrt.sv
module spk_isqrt
    import spk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              job_valid,
    input  logic [ACC_W-1:0]  job_energy,
    input  logic [BAND_W-1:0] job_band,
    output logic              busy,
    output logic              res_valid,
    output band_peak_t        res
);
    localparam int REM_W = AMP_W + 3;
    localparam int CNT_W = $clog2(AMP_W + 1);

    logic [RAD_W-1:0]  rad;
    logic [REM_W-1:0]  rem;
    logic [REM_W-1:0]  rem_sh;
    logic [REM_W-1:0]  trial;
    logic [AMP_W-1:0]  root;
    logic [CNT_W-1:0]  cnt;
    logic [BAND_W-1:0] band;
    logic              fits;

    always_comb begin
        rem_sh = {rem[REM_W-3:0], rad[RAD_W-1 -: 2]};
        trial  = REM_W'({root, 2'b01});
        fits   = rem_sh >= trial;
        res    = '{amp: root, band: band};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy      <= 1'b0;
            res_valid <= 1'b0;
            rad       <= '0;
            rem       <= '0;
            root      <= '0;
            cnt       <= '0;
            band      <= '0;
        end else begin
            res_valid <= 1'b0;
            if (job_valid) begin
                rad  <= RAD_W'(job_energy);
                rem  <= '0;
                root <= '0;
                cnt  <= '0;
                band <= job_band;
                busy <= 1'b1;
            end else if (busy) begin
                rad  <= rad << 2;
                rem  <= fits ? rem_sh - trial : rem_sh;
                root <= {root[AMP_W-2:0], fits};
                cnt  <= cnt + 1'b1;
                if (cnt == CNT_W'(AMP_W - 1)) begin
                    busy      <= 1'b0;
                    res_valid <= 1'b1;
                end
            end
        end
    end

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        job_valid |-> !busy) else $error("job while busy"); // R10
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid) else $error("result held"); // R3
endmodule

// File: rtl/spk_top2.sv
module spk_top2
    import spk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       upd_valid,
    input  band_peak_t upd,
    output band_peak_t first,
    output band_peak_t second
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            first  <= '0;
            second <= '0;
        end else if (upd_valid) begin
            if (upd.amp > first.amp) begin
                second <= first;
                first  <= upd;
            end else if ((upd.amp > second.amp) && (upd.amp < first.amp)) begin
                second <= upd;
            end
        end
    end

    AST_TOP_ORDER: assert property (@(posedge clk) disable iff (rst)
        first.amp >= second.amp) else $error("ranking order"); // R4
endmodule

// File: rtl/spk_frame_tx.sv
module spk_frame_tx
    import spk_pkg::*;
#(
    parameter int THRESH_Q = 1459
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       go,
    input  band_peak_t first,
    input  band_peak_t second,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_byte
);
    localparam int POS_W = $clog2(FRAME_LEN);

    band_peak_t       lo;
    band_peak_t       hi;
    logic [POS_W-1:0] pos;
    logic             active;

    function automatic logic [7:0] wave_type(input logic [AMP_W-1:0] amp);
        wave_type = (amp > AMP_W'(THRESH_Q)) ? 8'd0 : 8'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active <= 1'b0;
            pos    <= '0;
            lo     <= '0;
            hi     <= '0;
        end else if (go) begin
            active <= 1'b1;
            pos    <= '0;
            lo     <= (first.band > second.band) ? second : first;
            hi     <= (first.band > second.band) ? first : second;
        end else if (active && out_ready) begin
            if (pos == POS_W'(FRAME_LEN - 1)) begin
                active <= 1'b0;
                pos    <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    always_comb begin
        out_valid = active;
        case (pos)
            POS_W'(0): out_byte = FRAME_HEAD;
            POS_W'(1): out_byte = wave_type(lo.amp);
            POS_W'(2): out_byte = freq_code(lo.band);
            POS_W'(3): out_byte = wave_type(hi.amp);
            POS_W'(4): out_byte = freq_code(hi.band);
            default:   out_byte = FRAME_TAIL;
        endcase
    end

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst || clr)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))) else $error("byte hold"); // R8
endmodule

// File: rtl/spectral_peak_classifier.sv
module spectral_peak_classifier
    import spk_pkg::*;
#(
    parameter int THRESH_Q = 1459
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             bin_valid,
    input  logic [MAG_W-1:0] bin_mag,
    output logic             bin_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte
);
    logic              job_valid;
    logic [ACC_W-1:0]  job_energy;
    logic [BAND_W-1:0] job_band;
    logic              sqrt_busy;
    logic              res_valid;
    logic              spec_done;
    band_peak_t        res;
    band_peak_t        first;
    band_peak_t        second;

    spk_band_accum u_accum (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .bin_valid  (bin_valid),
        .bin_mag    (bin_mag),
        .bin_ready  (bin_ready),
        .sqrt_busy  (sqrt_busy),
        .res_valid  (res_valid),
        .job_valid  (job_valid),
        .job_energy (job_energy),
        .job_band   (job_band),
        .spec_done  (spec_done)
    );

    spk_isqrt u_isqrt (
        .clk        (clk),
        .rst        (rst),
        .clr        (start),
        .job_valid  (job_valid),
        .job_energy (job_energy),
        .job_band   (job_band),
        .busy       (sqrt_busy),
        .res_valid  (res_valid),
        .res        (res)
    );

    spk_top2 u_top2 (
        .clk        (clk),
        .rst        (rst),
        .clr        (start),
        .upd_valid  (res_valid),
        .upd        (res),
        .first      (first),
        .second     (second)
    );

    spk_frame_tx #(.THRESH_Q(THRESH_Q)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .clr        (start),
        .go         (spec_done),
        .first      (first),
        .second     (second),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_byte   (out_byte)
    );

    AST_HEAD_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_byte == FRAME_HEAD)) else $error("frame head"); // R7
    AST_TAIL_LAST: assert property (@(posedge clk) disable iff (rst || start)
        (out_valid && out_ready && out_byte == FRAME_TAIL) |=> !out_valid) else $error("frame tail"); // R8
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $fell(rst) |-> (!out_valid && !bin_ready)) else $error("reset state"); // R1
endmodule

// File: tb/spectral_peak_classifier_tb.sv
module spectral_peak_classifier_tb;
    localparam int CLK_PERIOD = 10;
    localparam int THRESH     = 1459;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        bin_valid;
    logic [15:0] bin_mag;
    logic        bin_ready;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_byte;

    int tests = 0;
    int fails = 0;
    logic [15:0] spec [0:1023];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spectral_peak_classifier u_dut (
        .clk(clk), .rst(rst), .start(start), .bin_valid(bin_valid), .bin_mag(bin_mag),
        .bin_ready(bin_ready), .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int band_f(input int i);
        longint n;
        n = longint'(i) * 2000000 + 2048 * 5000;
        return int'(n / (2 * 2048 * 5000));
    endfunction

    function automatic longint isq(input longint v);
        longint r = 0;
        for (int b = 24; b >= 0; b--) begin
            longint t = r + (longint'(1) << b);
            if (t * t <= v) r = t;
        end
        return r;
    endfunction

    // Independent reference of the requirements R2..R7, R9.
    task automatic model(output logic [7:0] ef [6]);
        longint acc = 0;
        longint m0 = 0, m1 = 0;
        int c0 = 0, c1 = 0, cur = -1;
        for (int i = 35; i <= 1000; i++) begin
            int b = (i <= 999) ? band_f(i) : -2;
            if (cur >= 0 && b != cur) begin
                longint a = isq(acc);
                int c = (5 * cur) / 2;
                if (a > m0) begin m1 = m0; c1 = c0; m0 = a; c0 = c; end
                else if (a > m1 && a < m0) begin m1 = a; c1 = c; end
                acc = 0;
            end
            cur = b;
            if (i <= 999) acc += longint'(spec[i]) * longint'(spec[i]);
        end
        ef[0] = 8'hFF; ef[5] = 8'hFE;
        if (c0 > c1) begin
            ef[1] = (m1 > THRESH) ? 8'd0 : 8'd1; ef[2] = 8'(c1);
            ef[3] = (m0 > THRESH) ? 8'd0 : 8'd1; ef[4] = 8'(c0);
        end else begin
            ef[1] = (m0 > THRESH) ? 8'd0 : 8'd1; ef[2] = 8'(c0);
            ef[3] = (m1 > THRESH) ? 8'd0 : 8'd1; ef[4] = 8'(c1);
        end
    endtask

    task automatic clear_spec;
        for (int i = 0; i < 1024; i++) spec[i] = 16'd0;
    endtask

    task automatic pulse_start;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_bins(input int last, output int stall_cycles);
        stall_cycles = 0;
        for (int i = 35; i <= last; i++) begin
            bin_valid = 1'b1;
            bin_mag   = spec[i];
            while (!bin_ready) begin
                stall_cycles++;
                @(negedge clk);
            end
            @(negedge clk);
        end
        bin_valid = 1'b0;
    endtask

    task automatic get_frame(input bit stall, output logic [7:0] fr [6]);
        int n = 0;
        int cyc = 0;
        bit held = 0;
        logic [7:0] hb = 8'd0;
        for (int k = 0; k < 6; k++) fr[k] = 8'h00;
        while (n < 6 && cyc < 20000) begin
            out_ready = stall ? (cyc % 3 == 2) : 1'b1;
            if (held) begin
                check(out_valid && out_byte == hb, "R8 byte held while stalled", out_byte, hb);
                held = 0;
            end
            if (out_valid) begin
                if (out_ready) begin fr[n] = out_byte; n++; end
                else begin held = 1; hb = out_byte; end
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        check(n == 6, "R8 six bytes delivered", n, 6);
        check(!out_valid, "R8 valid drops after tail", out_valid, 0);
    endtask

    task automatic run_and_compare(input string tag, input bit stall, output logic [7:0] fr [6]);
        logic [7:0] ef [6];
        int sc;
        pulse_start();
        send_bins(999, sc);
        get_frame(stall, fr);
        model(ef);
        for (int k = 0; k < 6; k++)
            check(fr[k] == ef[k], $sformatf("%s byte%0d (R7 R5 R6)", tag, k), fr[k], ef[k]);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; bin_valid = 1'b0; bin_mag = 16'd0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R1 out_valid low after reset", out_valid, 0);
        check(!bin_ready, "R1 bin_ready low before start", bin_ready, 0);
        pulse_start();
        check(bin_ready, "R1 bin_ready high after start", bin_ready, 1);
    endtask

    task automatic t_basic;
        logic [7:0] fr [6];
        clear_spec(); spec[82] = 16'h0800; spec[143] = 16'h0400;
        run_and_compare("basic", 0, fr);
        check(fr[2] == 8'd20, "R6 band 8 code", fr[2], 20);
        check(fr[4] == 8'd35, "R6 band 14 code", fr[4], 35);
        check(fr[1] == 8'd0 && fr[3] == 8'd1, "R5 sine then triangle", {fr[1], fr[3]}, 16'h0001);
    endtask

    task automatic t_swapped;
        logic [7:0] fr [6];
        clear_spec(); spec[82] = 16'h0400; spec[143] = 16'h0800;
        run_and_compare("swapped", 0, fr);
        check(fr[2] == 8'd20 && fr[1] == 8'd1, "R7 lower band first though weaker", fr[2], 20);
    endtask

    task automatic t_accumulate;
        logic [7:0] fr [6];
        clear_spec(); spec[82] = 16'h0400; spec[83] = 16'h0480;
        spec[143] = 16'h0300; spec[144] = 16'h0400;
        run_and_compare("accum", 0, fr);
        check(fr[1] == 8'd0, "R3 summed band energy above threshold", fr[1], 0);
        check(fr[3] == 8'd1, "R3 summed 5.0 band stays triangle", fr[3], 1);
    endtask

    task automatic t_threshold;
        logic [7:0] fr [6];
        clear_spec(); spec[82] = 16'd1459; spec[143] = 16'd1460;
        run_and_compare("thresh", 0, fr);
        check(fr[1] == 8'd1, "R5 equal to threshold is triangle", fr[1], 1);
        check(fr[3] == 8'd0, "R5 above threshold is sine", fr[3], 0);
    endtask

    task automatic t_single;
        logic [7:0] fr [6];
        clear_spec(); spec[143] = 16'h0800;
        run_and_compare("single", 0, fr);
        check(fr[2] == 8'd0 && fr[1] == 8'd1, "R9 missing tone first with code 0", fr[2], 0);
        check(fr[4] == 8'd35, "R9 present tone second", fr[4], 35);
    endtask

    task automatic t_tie;
        logic [7:0] fr [6];
        clear_spec(); spec[82] = 16'h0800; spec[143] = 16'h0800;
        run_and_compare("tie", 0, fr);
        check(fr[2] == 8'd0, "R4 equal amplitude ignored", fr[2], 0);
        check(fr[4] == 8'd20, "R4 first band kept", fr[4], 20);
    endtask

    task automatic t_last_band;
        logic [7:0] fr [6];
        logic [7:0] ef [6];
        int sc;
        clear_spec(); spec[82] = 16'h0400; spec[999] = 16'h0A00;
        pulse_start();
        send_bins(999, sc);
        check(sc > 0, "R10 bin_ready drops during root", sc, 1);
        get_frame(0, fr);
        model(ef);
        check(fr[4] == 8'd245, "R10 R2 single-bin last band ranked", fr[4], 245);
        check(fr[3] == 8'd0, "R10 last band type", fr[3], 0);
        check(fr[2] == ef[2], "R10 other band code", fr[2], ef[2]);
    endtask

    task automatic t_stall;
        logic [7:0] fr [6];
        clear_spec(); spec[100] = 16'h0700; spec[300] = 16'h0200;
        run_and_compare("stall", 1, fr);
    endtask

    task automatic t_restart;
        logic [7:0] fr [6];
        int sc;
        clear_spec(); spec[60] = 16'h2000; spec[400] = 16'h2000;
        pulse_start();
        send_bins(450, sc);
        clear_spec(); spec[200] = 16'h0800; spec[250] = 16'h0300;
        run_and_compare("restart", 0, fr);
        check(fr[2] == 8'(((band_f(200)) * 5) / 2), "R11 stale bins discarded", fr[2], ((band_f(200)) * 5) / 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_swapped();
        t_accumulate();
        t_threshold();
        t_single();
        t_tie();
        t_last_band();
        t_stall();
        t_restart();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule